// File: doc/BRIEF.md
# Video Black-Level Clamp Timing Generator

This block runs in the pixel clock domain of a digitized video path. It produces one clamp-enable window per horizontal line so that the analog front end can restore its black reference. The window is timed from the trailing edge of horizontal sync, so it always lands on the back porch however wide the sync pulse is. The sync input passes through a two-flop synchronizer. A polarity input defines which edge of the sync counts as trailing, so a three-level sync can be timed from its rising edge.

Two 8-bit settings shape the window. The delay counts the pixel periods from the detected trailing edge to the start of the clamp. The length counts the pixel periods for which the clamp is held. Both are sampled at the moment a window starts. The block also turns three per-channel select bits into target codes for the converters: either ground (code 0) or midscale (code 128).

Top module: `clamp_timing_gen`

## Requirements
- R1: With `sync_pol_i`=1 the trailing edge is a falling edge of `hsync_i`; with `sync_pol_i`=0 it is a rising edge. A leading edge starts no clamp window.
- R2: Let n be the first rising clock edge that samples the trailing level of `hsync_i`. Then `clamp_o` goes high right after rising edge n+3+P, where P is `place_i`.
- R3: Once high, `clamp_o` stays high for exactly D clock cycles, where D is `dur_i`, and then falls.
- R4: A length of D=0 produces no clamp pulse for that line, whatever P is.
- R5: With P=0 and D>0, `clamp_o` goes high right after edge n+3.
- R6: P and D each work over the full 8-bit range, including P=255 with D=255, and a delay of 38 pixels for a three-level sync timed from its rising edge.
- R7: A new trailing edge that arrives while a delay or clamp count is still running restarts timing from the new edge. From edge n+3 of the new edge, `clamp_o` follows the new window only, so a window that is already running ends at once when the new P is non-zero.
- R8: P and D are sampled at edge n+3. Changes to `place_i` or `dur_i` after that edge do not alter the window in progress.
- R9: Bit i of `clamp_sel_i` selects the target of channel i, which is output on `target_code_o[8i+7:8i]`: 1 gives code 128 (midscale) and 0 gives code 0 (ground). The code updates one clock edge after the select bit changes.
- R10: While `rst_n` is low, `clamp_o` is 0 and all target codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, asynchronous to the pixel clock |
| sync_pol_i | input | 1 | 1: active-high sync; 0: active-low sync or three-level rising reference |
| place_i | input | 8 | Delay, in pixel periods, from the trailing edge to the clamp start |
| dur_i | input | 8 | Clamp length in pixel periods (0 disables the clamp) |
| clamp_sel_i | input | 3 | Per-channel target select (1 midscale, 0 ground) |
| clamp_o | output | 1 | Clamp enable |
| target_code_o | output | 24 | Three 8-bit target codes, channel 0 in the low byte |

## Verification
The hardest case to reach from the ports is a trailing edge that lands while an earlier window is still counting. For three cycles after the new edge, the old window keeps running, and only after that does the restart take over. The stimulus reaches this case with directed lines whose gaps fall inside the delay phase and inside the clamp phase. Random lines also get a short gap about one time in four. The bench's timeline model keeps the previous window and the current one, and it switches between them at edge n+3. Setting changes made during a window cover the sampling rule.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

   typedef enum logic [1:0] {
      CW_IDLE  = 2'd0,
      CW_PLACE = 2'd1,
      CW_HOLD  = 2'd2
   } cw_state_t;

endpackage

// File: rtl/clamp_sync_edge.sv
module clamp_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_i,
   input  logic pol_i,
   output logic trail_o
);

   localparam int CHAIN_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("clamp_sync_edge: STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain_q;
   logic               trail_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= hsync_i;
   end

   for (genvar s = 1; s < CHAIN_W; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   // Trailing edge: the older sample was active and the newer one is not.
   always_comb begin
      if (pol_i) trail_d = chain_q[STAGES] & ~chain_q[STAGES-1];
      else       trail_d = ~chain_q[STAGES] & chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trail_o <= 1'b0;
      else        trail_o <= trail_d;
   end

endmodule

// File: rtl/clamp_window_ctl.sv
module clamp_window_ctl
   import clamp_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] place_i,
   input  logic [CNT_W-1:0] dur_i,
   output logic             clamp_o
);

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("clamp_window_ctl: CNT_W must lie in 2..16");
   end

   cw_state_t        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] dur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CW_IDLE;
         cnt_q   <= '0;
         dur_q   <= '0;
      end else if (start_i) begin
         dur_q <= dur_i;
         if (dur_i == '0) begin
            state_q <= CW_IDLE;
            cnt_q   <= '0;
         end else if (place_i == '0) begin
            state_q <= CW_HOLD;
            cnt_q   <= dur_i - 1'b1;
         end else begin
            state_q <= CW_PLACE;
            cnt_q   <= place_i - 1'b1;
         end
      end else begin
         case (state_q)
            CW_PLACE: begin
               if (cnt_q == '0) begin
                  state_q <= CW_HOLD;
                  cnt_q   <= dur_q - 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            CW_HOLD: begin
               if (cnt_q == '0) state_q <= CW_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: begin
               state_q <= CW_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign clamp_o = (state_q == CW_HOLD);

endmodule

// File: rtl/clamp_target_map.sv
module clamp_target_map #(
   parameter int NUM_CH = 3,
   parameter int CODE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        sel_i,
   output logic [NUM_CH*CODE_W-1:0] code_o
);

   if (NUM_CH < 1 || CODE_W < 2) begin : g_bad_map
      $error("clamp_target_map: NUM_CH >= 1 and CODE_W >= 2 required");
   end

   localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         code_o[ch*CODE_W +: CODE_W] <= '0;
         else if (sel_i[ch]) code_o[ch*CODE_W +: CODE_W] <= MID_CODE;
         else                code_o[ch*CODE_W +: CODE_W] <= '0;
      end
   end

endmodule

// File: rtl/clamp_timing_gen.sv
module clamp_timing_gen #(
   parameter int CNT_W       = 8,
   parameter int NUM_CH      = 3,
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk_pix,
   input  logic                     rst_n,
   input  logic                     hsync_i,
   input  logic                     sync_pol_i,
   input  logic [CNT_W-1:0]         place_i,
   input  logic [CNT_W-1:0]         dur_i,
   input  logic [NUM_CH-1:0]        clamp_sel_i,
   output logic                     clamp_o,
   output logic [NUM_CH*CODE_W-1:0] target_code_o
);

   logic trail_pulse;

   clamp_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk_pix),
      .rst_n   (rst_n),
      .hsync_i (hsync_i),
      .pol_i   (sync_pol_i),
      .trail_o (trail_pulse)
   );

   clamp_window_ctl #(.CNT_W(CNT_W)) u_win (
      .clk     (clk_pix),
      .rst_n   (rst_n),
      .start_i (trail_pulse),
      .place_i (place_i),
      .dur_i   (dur_i),
      .clamp_o (clamp_o)
   );

   clamp_target_map #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_map (
      .clk    (clk_pix),
      .rst_n  (rst_n),
      .sel_i  (clamp_sel_i),
      .code_o (target_code_o)
   );

endmodule

// File: rtl/clamp_timing_chk.sv
module clamp_timing_chk #(
   parameter int CNT_W  = 8,
   parameter int NUM_CH = 3,
   parameter int CODE_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     trail,
   input logic [CNT_W-1:0]         place,
   input logic [CNT_W-1:0]         dur,
   input logic                     clamp,
   input logic [NUM_CH-1:0]        sel,
   input logic [NUM_CH*CODE_W-1:0] code
);

   localparam int RUN_W   = CNT_W + 1;
   localparam int MAX_RUN = (1 << CNT_W) - 1;
   localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             run_q <= '0;
      else if (!clamp)                        run_q <= '0;
      else if (run_q != {RUN_W{1'b1}})        run_q <= run_q + 1'b1;
   end

   // R1
   trail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trail |=> !trail);

   // R7
   restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trail && place != '0) |=> !clamp);

   // R4
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trail && dur == '0) |=> !clamp);

   // R5
   zero_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trail && place == '0 && dur != '0) |=> clamp);

   // R3
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(run_q) <= MAX_RUN);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_map_chk
      // R9
      mid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         sel[ch] |=> code[ch*CODE_W +: CODE_W] == MID_CODE);
      // R9
      gnd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !sel[ch] |=> code[ch*CODE_W +: CODE_W] == '0);
   end

endmodule

bind clamp_timing_gen clamp_timing_chk #(
   .CNT_W  (CNT_W),
   .NUM_CH (NUM_CH),
   .CODE_W (CODE_W)
) u_chk (
   .clk   (clk_pix),
   .rst_n (rst_n),
   .trail (trail_pulse),
   .place (place_i),
   .dur   (dur_i),
   .clamp (clamp_o),
   .sel   (clamp_sel_i),
   .code  (target_code_o)
);

// File: tb/test_clamp_timing_gen.sv
module test_clamp_timing_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync = 1'b0;
   logic        pol = 1'b1;
   logic [7:0]  place = 8'd8;
   logic [7:0]  dur = 8'd20;
   logic [2:0]  sel = 3'b000;
   logic        clamp;
   logic [23:0] codes;

   int    errors = 0;
   int    checks = 0;
   int    cyc = 0;
   bit    mon_en = 1'b0;
   bit    finished = 1'b0;
   string cur_req = "R2";

   // window records: previous and current trailing edges
   int a_n = -100000, a_p = 0, a_d = 0;
   int b_n = -100000, b_p = 0, b_d = 0;

   clamp_timing_gen i_clamp_timing_gen (
      .clk_pix       (clk),
      .rst_n         (rst_n),
      .hsync_i       (hsync),
      .sync_pol_i    (pol),
      .place_i       (place),
      .dur_i         (dur),
      .clamp_sel_i   (sel),
      .clamp_o       (clamp),
      .target_code_o (codes)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic bit in_win(int n, int p, int d, int c);
      return (c - n >= 3 + p) && (c - n < 3 + p + d);
   endfunction

   function automatic bit exp_clamp(int c);
      if (c < b_n + 3) return in_win(a_n, a_p, a_d, c);
      return in_win(b_n, b_p, b_d, c);
   endfunction

   function automatic logic [7:0] exp_code(logic s);
      return s ? 8'd128 : 8'd0;
   endfunction

   task automatic check(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         if (errors < 30)
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en) check(cur_req, int'(clamp), int'(exp_clamp(cyc)));
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_model();
      a_n = -100000; a_d = 0; a_p = 0;
      b_n = -100000; b_d = 0; b_p = 0;
   endtask

   // active for width cycles, then trailing edge with settings p, d
   task automatic line(int width, int p, int d);
      hsync = pol;
      idle(width);
      hsync = ~pol;
      place = 8'(p);
      dur   = 8'(d);
      a_n = b_n; a_p = b_p; a_d = b_d;
      b_n = cyc + 1; b_p = p; b_d = d;
   endtask

   task automatic random_lines(int count, string req);
      for (int i = 0; i < count; i++) begin
         int w, p, d, gap;
         cur_req = req;
         w = 2 + int'($urandom % 6);
         p = int'($urandom % 40);
         d = int'($urandom % 40);
         if ($urandom % 4 == 0) begin
            gap = 2 + int'($urandom % 20);
            cur_req = "R7";
         end else begin
            gap = 3 + p + d + 2 + int'($urandom % 5);
         end
         line(w, p, d);
         if (gap > 6) begin
            idle(5);
            // R8: later setting changes do not touch this window
            place = 8'($urandom);
            dur   = 8'($urandom);
            idle(gap - 5);
         end else begin
            idle(gap);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd4711));
      // R10: reset state
      sel = 3'b111;
      repeat (3) begin
         @(negedge clk) hsync = ~hsync;
      end
      @(negedge clk);
      check("R10", int'(clamp), 0);
      check("R10", int'(codes), 0);
      hsync = 1'b0;
      rst_n = 1'b1;
      sel = 3'b000;
      idle(5);

      // R9: target codes per channel, one edge of latency
      for (int s = 0; s < 8; s++) begin
         sel = 3'(s);
         @(negedge clk);
         for (int ch = 0; ch < 3; ch++)
            check("R9", int'(codes[ch*8 +: 8]), int'(exp_code(sel[ch])));
      end

      mon_en = 1'b1;
      cur_req = "R2"; line(4, 8, 20);  idle(40);
      cur_req = "R2"; line(6, 3, 7);   idle(20);
      cur_req = "R5"; line(3, 0, 5);   idle(12);
      cur_req = "R4"; line(3, 3, 0);   idle(12);
      cur_req = "R4"; line(3, 0, 0);   idle(12);
      cur_req = "R3"; line(2, 1, 1);   idle(10);
      cur_req = "R6"; line(5, 255, 255); idle(520);

      // R7: restart during delay, during clamp, with zero delay
      cur_req = "R7"; line(3, 10, 20); idle(5);
      line(2, 4, 6);  idle(30);
      line(3, 2, 30); idle(15);
      line(3, 6, 5);  idle(30);
      line(3, 0, 20); idle(8);
      line(2, 0, 4);  idle(20);

      // R8: settings changed after sampling
      cur_req = "R8"; line(3, 6, 12); idle(5);
      place = 8'd200; dur = 8'd0;
      idle(30);

      random_lines(80, "R2");

      // R1: switch to rising-edge reference
      mon_en = 1'b0;
      pol = 1'b0;
      hsync = 1'b1;
      idle(600);
      clear_model();
      mon_en = 1'b1;
      cur_req = "R1"; line(4, 5, 9);  idle(25);
      cur_req = "R6"; line(4, 38, 20); idle(70);
      random_lines(30, "R1");
      idle(10);
      mon_en = 1'b0;

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(64'd200000 * 20);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule